// File: doc/BRIEF.md
# Thermometer-to-binary sample compressor

This block sits behind a bank of amplitude comparators whose outputs are sampled many times within each system clock period. Every system clock it receives one group of sampled comparator words in parallel, one word per sub-clock sample. Each word is a thermometer pattern: bit 0 belongs to the lowest threshold. The block reduces each word to a small binary level code and packs the codes of the whole group into one word.

The packed codes are written into a pair of storage slots that take turns. The first slot is written in one period and the second in the next. Writing never pauses, so every period is captured and capture has no dead time. The block outputs the most recently written slot, the index of that slot, and a flag that is set when any sample in that period has a non-zero level.

A narrow mode keeps only the lowest four comparators. It serves front ends that are fitted with fewer thresholds.

Top module: `tcmp_top`

## Requirements
- R1: For each sample, the level code is the position of the highest asserted comparator bit plus one, and is 0 when no bit is asserted. Bit 0 is the lowest threshold, and sample s occupies bits [s*15 +: 15] of `therm_in`. For a clean thermometer pattern the code equals the number of asserted bits, and the full pattern gives 15.
- R2: A non-monotonic pattern, in which lower bits are clear beneath an asserted bit, is coded by its highest asserted bit alone. The clear bits below it do not lower the code.
- R3: `level_out` holds sample s in bits [4*s+3:4*s]. Sample 0 is the earliest sample and sits in the least significant nibble.
- R4: The codes for a group presented before a rising edge appear on `level_out` after that edge, and are replaced by the next group's codes after the following edge.
- R5: `hit_out` is 1 exactly when at least one of the 16 codes shown on `level_out` is non-zero.
- R6: `out_slot` gives the slot being shown, with 0 for the first slot and 1 for the second. It alternates on every clock after reset, and every group is captured with no skipped period.
- R7: While `narrow_mode` is 1, comparator bits 4 to 14 of every sample are ignored. Codes are then at most 4, and a sample that has only those upper bits set gives 0.
- R8: While `rst` is 1, both slots clear: `level_out` is 0, `hit_out` is 0 and `out_slot` is 1. The first group captured after reset goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one sample group per period |
| rst | input | 1 | Synchronous active-high reset |
| narrow_mode | input | 1 | 1 = use only the lowest four comparators |
| therm_in | input | 240 | 16 sampled comparator words of 15 bits, sample 0 lowest |
| level_out | output | 64 | 16 packed 4-bit level codes of the last captured period |
| hit_out | output | 1 | Any non-zero code in the last captured period |
| out_slot | output | 1 | Slot shown on the outputs (0 = first, 1 = second) |

## Verification
The main function is driven with several kinds of group:
- **Random clean thermometers** check the basic count.
- **A staircase** gives each sample a different level, so a swapped or shifted nibble shows at once.
- **Random words with bubbles** separate highest-bit priority from ones counting.
- **An isolated single-sample pulse** followed by empty groups pins the one-cycle latency.
- **Sparse groups** with at most one hot sample tell the hit flag apart from a flag stuck at either value.
- **Narrow-mode words** with only upper bits set must compress to zero.

A reset in the middle of a run confirms that capture restarts in the first slot.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam int DEF_THRESHOLDS = 15;
    localparam int DEF_SAMPLES    = 16;
    localparam int DEF_NARROW     = 4;

    typedef enum logic {
        SLOT_FIRST  = 1'b0,
        SLOT_SECOND = 1'b1
    } slot_sel_e;

    function automatic int level_bits(input int n_thresholds);
        return $clog2(n_thresholds + 1);
    endfunction

    function automatic slot_sel_e other_slot(input slot_sel_e s);
        return (s == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
    endfunction

endpackage

// File: rtl/tcmp_level_enc.sv
module tcmp_level_enc #(
    parameter int N_THR      = 15,
    parameter int NARROW_THR = 4,
    parameter int CODE_W     = 4
) (
    input  logic [N_THR-1:0]  therm,
    input  logic              narrow,
    output logic [CODE_W-1:0] level
);

    logic [N_THR-1:0] keep;
    logic [N_THR-1:0] masked;

    for (genvar i = 0; i < N_THR; i++) begin : g_mask
        if (i < NARROW_THR) begin : g_low
            assign keep[i] = 1'b1;
        end else begin : g_high
            assign keep[i] = ~narrow;
        end
    end

    assign masked = therm & keep;

    // Ascending scan: the highest asserted comparator wins, so bubbles
    // below it are absorbed.
    always_comb begin
        level = '0;
        for (int i = 0; i < N_THR; i++) begin
            if (masked[i]) begin
                level = CODE_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/tcmp_pingpong.sv
module tcmp_pingpong
    import tcmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_hit,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit,
    output logic              rd_slot
);

    logic [DATA_W-1:0] mem   [2];
    logic              hit_q [2];
    slot_sel_e         wr_ptr;
    logic              wr_idx;
    logic              rd_idx;

    assign wr_idx = wr_ptr;
    assign rd_idx = other_slot(wr_ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem[0]   <= '0;
            mem[1]   <= '0;
            hit_q[0] <= 1'b0;
            hit_q[1] <= 1'b0;
            wr_ptr   <= SLOT_FIRST;
        end else begin
            mem[wr_idx]   <= wr_data;
            hit_q[wr_idx] <= wr_hit;
            wr_ptr        <= other_slot(wr_ptr);
        end
    end

    assign rd_data = mem[rd_idx];
    assign rd_hit  = hit_q[rd_idx];
    assign rd_slot = rd_idx;

    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wr_ptr != $past(wr_ptr))) else $error("pointer stalled"); // R6

    AST_SECOND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr == SLOT_FIRST) |=> ($stable(mem[1]) && $stable(hit_q[1]))) else $error("second slot disturbed"); // R6

    AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr == SLOT_SECOND) |=> ($stable(mem[0]) && $stable(hit_q[0]))) else $error("first slot disturbed"); // R6

endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
    import tcmp_pkg::*;
#(
    parameter int N_THR      = DEF_THRESHOLDS,
    parameter int N_SAMP     = DEF_SAMPLES,
    parameter int NARROW_THR = DEF_NARROW
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             narrow_mode,
    input  logic [N_SAMP*N_THR-1:0]          therm_in,
    output logic [N_SAMP*level_bits(N_THR)-1:0] level_out,
    output logic                             hit_out,
    output logic                             out_slot
);

    localparam int CODE_W = level_bits(N_THR);
    localparam int PACK_W = N_SAMP * CODE_W;

    logic [PACK_W-1:0] codes;
    logic              any_hit;
    logic [N_SAMP-1:0] over_narrow;

    for (genvar s = 0; s < N_SAMP; s++) begin : g_samp
        tcmp_level_enc #(
            .N_THR      (N_THR),
            .NARROW_THR (NARROW_THR),
            .CODE_W     (CODE_W)
        ) enc_i (
            .therm  (therm_in[s*N_THR +: N_THR]),
            .narrow (narrow_mode),
            .level  (codes[s*CODE_W +: CODE_W])
        );
        assign over_narrow[s] = (level_out[s*CODE_W +: CODE_W] > CODE_W'(NARROW_THR));
    end

    assign any_hit = |codes;

    tcmp_pingpong #(
        .DATA_W (PACK_W)
    ) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_data (codes),
        .wr_hit  (any_hit),
        .rd_data (level_out),
        .rd_hit  (hit_out),
        .rd_slot (out_slot)
    );

    AST_HIT_MATCH: assert property (@(posedge clk) disable iff (rst)
        hit_out == (level_out != '0)) else $error("hit flag mismatch"); // R5

    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        narrow_mode |=> (over_narrow == '0)) else $error("narrow code too large"); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (level_out == '0 && !hit_out && out_slot)) else $error("reset state wrong"); // R8

endmodule

// File: tb/tcmp_top_tb_top.sv
module tcmp_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 15;
    localparam int NS = 16;
    localparam int CW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              narrow_mode = 1'b0;
    logic [NS*NT-1:0]  therm_in = '0;
    logic [NS*CW-1:0]  level_out;
    logic              hit_out;
    logic              out_slot;

    logic [NT-1:0]     grp [NS];
    int                n_checks = 0;
    int                n_fail = 0;
    bit                done = 1'b0;
    logic              exp_slot;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcmp_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .narrow_mode (narrow_mode),
        .therm_in    (therm_in),
        .level_out   (level_out),
        .hit_out     (hit_out),
        .out_slot    (out_slot)
    );

    // Reference: scan downward from the top usable comparator.
    function automatic int ref_level(input logic [NT-1:0] w, input bit nar);
        int lim = nar ? 4 : NT;
        for (int b = lim - 1; b >= 0; b--) begin
            if (w[b]) return b + 1;
        end
        return 0;
    endfunction

    function automatic logic [NT-1:0] thermo(input int lvl);
        logic [NT-1:0] w = '0;
        for (int b = 0; b < lvl; b++) w[b] = 1'b1;
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_group(input string tag, input bit nar);
        logic [NS*CW-1:0] e_lvl;
        bit e_hit = 1'b0;
        for (int s = 0; s < NS; s++) begin
            therm_in[s*NT +: NT] = grp[s];
            e_lvl[s*CW +: CW] = CW'(ref_level(grp[s], nar));
            if (ref_level(grp[s], nar) != 0) e_hit = 1'b1;
        end
        narrow_mode = nar;
        @(negedge clk);
        check(tag, 64'(level_out), 64'(e_lvl));
        check("R5", 64'(hit_out), 64'(e_hit));
        exp_slot = ~exp_slot;
        check("R6", 64'(out_slot), 64'(exp_slot));
    endtask

    task automatic reset_phase(input int n);
        rst = 1'b1;
        for (int s = 0; s < NS; s++) grp[s] = thermo(s % 16);
        for (int s = 0; s < NS; s++) therm_in[s*NT +: NT] = grp[s];
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R8", 64'(level_out), 64'd0);
            check("R8", 64'(hit_out), 64'd0);
            check("R8", 64'(out_slot), 64'd1);
        end
        rst = 1'b0;
        exp_slot = 1'b1;
    endtask

    task automatic clear_grp();
        for (int s = 0; s < NS; s++) grp[s] = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R6: watchdog expired, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        reset_phase(3);

        // R1: all zero, full scale, random clean thermometers
        clear_grp();
        run_group("R1", 1'b0);
        for (int s = 0; s < NS; s++) grp[s] = thermo(15);
        run_group("R1", 1'b0);
        for (int k = 0; k < 20; k++) begin
            for (int s = 0; s < NS; s++) grp[s] = thermo(int'($urandom_range(15, 0)));
            run_group("R1", 1'b0);
        end

        // R3: staircase up and down to pin nibble positions
        for (int s = 0; s < NS; s++) grp[s] = thermo(s);
        run_group("R3", 1'b0);
        for (int s = 0; s < NS; s++) grp[s] = thermo(15 - s);
        run_group("R3", 1'b0);
        clear_grp();
        grp[0] = thermo(1);
        run_group("R3", 1'b0);

        // R2: bubbles
        clear_grp();
        for (int s = 0; s < NS; s++) grp[s] = NT'(15'h0001 << (s % NT)) | NT'(1);
        grp[5] = 15'b100_0000_0000_0000;
        grp[6] = 15'b000_0000_1010_0100;
        run_group("R2", 1'b0);
        for (int k = 0; k < 20; k++) begin
            for (int s = 0; s < NS; s++) grp[s] = NT'($urandom);
            run_group("R2", 1'b0);
        end

        // R4: isolated pulse, then empty periods
        clear_grp();
        grp[7] = thermo(9);
        run_group("R4", 1'b0);
        clear_grp();
        run_group("R4", 1'b0);
        run_group("R4", 1'b0);

        // R7: narrow mode
        for (int s = 0; s < NS; s++) grp[s] = 15'b111_1111_1111_0000;
        run_group("R7", 1'b1);
        for (int s = 0; s < NS; s++) grp[s] = thermo(15);
        run_group("R7", 1'b1);
        for (int k = 0; k < 20; k++) begin
            for (int s = 0; s < NS; s++) grp[s] = NT'($urandom);
            run_group("R7", 1'b1);
        end
        for (int s = 0; s < NS; s++) grp[s] = 15'b111_1111_1111_0000;
        run_group("R7", 1'b0);

        // R5: sparse hits
        for (int k = 0; k < 30; k++) begin
            clear_grp();
            if ($urandom_range(3, 0) == 0) grp[$urandom_range(NS-1, 0)] = thermo(int'($urandom_range(15, 1)));
            run_group("R5", 1'b0);
        end

        // R8: mid-run reset, capture restarts in the first slot
        @(negedge clk);
        exp_slot = ~exp_slot;
        reset_phase(1);
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < NS; s++) grp[s] = thermo(int'($urandom_range(15, 0)));
            run_group("R1", 1'b0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule